// File: doc/BRIEF.md
# Sync-to-Strobe Latency Measurement and Read-Start Alignment

This block runs one measurement lane for each transmit channel. A single shared sync input marks the reference instant. Every qualifying sync edge restarts all lanes. Each lane then counts sample-rate enables until its own transmit strobe arrives. It holds that count as the channel's latency in whole samples, with a valid flag, and raises a saturation flag if the count hit its ceiling.

At the same strobe, the lane loads a programmable per-channel delay. Once that many further sample enables have passed, it raises the channel's FIFO read-enable. The enable stays high until the next sync edge. It moves the point where reading of the channel's FIFO begins and does not delay the data itself.

Delay values are computed outside the block, for example as the largest measured latency minus the channel's own latency. With such values, every channel starts reading at the same sample, so all channels see the same transmit latency.

Top module: `sync_strobe_align`

## Requirements
- R1: While reset is held, and in the first cycle after release, `lat_out`, `lat_valid`, `lat_ovf` and `rd_en` are all zero.
- R2: A channel's latched latency equals the number of cycles with `samp_en` high that lie strictly between the sync-edge cycle and that channel's strobe cycle. `lat_out` and `lat_valid` take this value on the clock edge that samples the strobe.
- R3: Every qualifying sync edge restarts the count of all channels. On the clock edge that samples it, it also clears `lat_valid` and `rd_en`, so only the last edge before a strobe is measured from.
- R4: After a sync edge, only the first strobe of a channel is captured. Later strobes leave `lat_out` unchanged. A strobe in the same cycle as a sync edge is not captured.
- R5: The count saturates at 2^CNT_W-1. A capture at that value sets `lat_ovf` along with `lat_valid`. Otherwise the capture clears `lat_ovf`.
- R6: With a delay value of 0, `rd_en` rises on the same edge as `lat_valid`.
- R7: With a delay value D>0, `rd_en` rises on the edge that samples the D-th `samp_en` cycle after the strobe cycle. D is taken from `dly_cfg[ch*DLY_W +: DLY_W]` in the strobe cycle, and later changes have no effect.
- R8: Channels are independent. Two channels whose strobe offset plus delay, counted in sample enables, are equal raise `rd_en` on the same edge.
- R9: With SYNC_EDGE = EDGE_RISE (the default), only a low-to-high change of `sync_in` restarts the lanes. Holding `sync_in` high does not restart them again, and a falling edge has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| samp_en | input | 1 | One-cycle sample-rate enable |
| sync_in | input | 1 | Shared multichip sync pulse |
| strobe_in | input | NUM_CH | Per-channel transmit strobe |
| dly_cfg | input | NUM_CH*DLY_W | Per-channel read-start delay in samples |
| lat_out | output | NUM_CH*CNT_W | Latched latency per channel |
| lat_valid | output | NUM_CH | Latency captured since the last sync edge |
| lat_ovf | output | NUM_CH | Captured latency is saturated |
| rd_en | output | NUM_CH | Delayed FIFO read-enable per channel |

## Verification
The latency, valid and saturation outputs are due on the clock edge that samples the strobe. The clearing caused by a sync edge is due on the edge that samples that edge. `rd_en` is due on the strobe edge when the delay is zero. Otherwise it is due on the edge that samples the D-th sample enable after the strobe. The driver tasks stamp every expected item with the number of the edge at which it must appear. The monitor compares only items whose stamp equals the current edge count, reading outputs at the falling clock edge. Low values are also expected in the cycles before `rd_en` is due, so a read-enable that rises early is caught as well as one that rises late.

// File: rtl/sync_align_pkg.sv
package sync_align_pkg;
   typedef enum logic {
      EDGE_FALL = 1'b0,
      EDGE_RISE = 1'b1
   } edge_sel_e;
endpackage

// File: rtl/sync_edge_det.sv
module sync_edge_det import sync_align_pkg::*; #(
   parameter edge_sel_e SYNC_EDGE = EDGE_RISE
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_in,
   output logic edge_o
);
   logic sync_q;

   generate
      if (SYNC_EDGE == EDGE_RISE) begin : g_rise
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q <= 1'b0;
            else        sync_q <= sync_in;
         end
         assign edge_o = sync_in & ~sync_q;
      end else begin : g_fall
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q <= 1'b1;
            else        sync_q <= sync_in;
         end
         assign edge_o = ~sync_in & sync_q;
      end
   endgenerate
endmodule

// File: rtl/lat_meas.sv
module lat_meas #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             samp_en,
   input  logic             strobe,
   output logic             capture,
   output logic [CNT_W-1:0] lat,
   output logic             valid,
   output logic             ovf
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt;
   logic             armed;

   assign capture = strobe & armed & ~restart;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt   <= '0;
         armed <= 1'b0;
         lat   <= '0;
         valid <= 1'b0;
         ovf   <= 1'b0;
      end else if (restart) begin
         cnt   <= '0;
         armed <= 1'b1;
         valid <= 1'b0;
         ovf   <= 1'b0;
      end else if (capture) begin
         lat   <= cnt;
         valid <= 1'b1;
         ovf   <= (cnt == CNT_MAX);
         armed <= 1'b0;
      end else if (armed && samp_en && cnt != CNT_MAX) begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/read_gate.sv
module read_gate #(
   parameter int DLY_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             capture,
   input  logic             samp_en,
   input  logic [DLY_W-1:0] dly,
   output logic             rd_en
);
   logic [DLY_W-1:0] dcnt;
   logic             pend;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dcnt  <= '0;
         pend  <= 1'b0;
         rd_en <= 1'b0;
      end else if (restart) begin
         dcnt  <= '0;
         pend  <= 1'b0;
         rd_en <= 1'b0;
      end else if (capture) begin
         if (dly == '0) begin
            rd_en <= 1'b1;
         end else begin
            dcnt <= dly;
            pend <= 1'b1;
         end
      end else if (pend && samp_en) begin
         dcnt <= dcnt - 1'b1;
         if (dcnt == {{(DLY_W-1){1'b0}}, 1'b1}) begin
            rd_en <= 1'b1;
            pend  <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/sync_strobe_align.sv
module sync_strobe_align import sync_align_pkg::*; #(
   parameter int        NUM_CH    = 4,
   parameter int        CNT_W     = 8,
   parameter int        DLY_W     = 6,
   parameter edge_sel_e SYNC_EDGE = EDGE_RISE
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    samp_en,
   input  logic                    sync_in,
   input  logic [NUM_CH-1:0]       strobe_in,
   input  logic [NUM_CH*DLY_W-1:0] dly_cfg,
   output logic [NUM_CH*CNT_W-1:0] lat_out,
   output logic [NUM_CH-1:0]       lat_valid,
   output logic [NUM_CH-1:0]       lat_ovf,
   output logic [NUM_CH-1:0]       rd_en
);
   generate
      if (NUM_CH < 1) begin : g_bad_ch
         $error("NUM_CH must be at least 1");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("CNT_W must be at least 2");
      end
      if (DLY_W < 1) begin : g_bad_dly
         $error("DLY_W must be at least 1");
      end
   endgenerate

   logic sync_edge;

   sync_edge_det #(.SYNC_EDGE(SYNC_EDGE)) u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .sync_in (sync_in),
      .edge_o  (sync_edge)
   );

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         logic cap;

         lat_meas #(.CNT_W(CNT_W)) u_meas (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (sync_edge),
            .samp_en (samp_en),
            .strobe  (strobe_in[c]),
            .capture (cap),
            .lat     (lat_out[c*CNT_W +: CNT_W]),
            .valid   (lat_valid[c]),
            .ovf     (lat_ovf[c])
         );

         read_gate #(.DLY_W(DLY_W)) u_gate (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (sync_edge),
            .capture (cap),
            .samp_en (samp_en),
            .dly     (dly_cfg[c*DLY_W +: DLY_W]),
            .rd_en   (rd_en[c])
         );
      end
   endgenerate
endmodule

// File: rtl/sync_strobe_align_chk.sv
module sync_strobe_align_chk import sync_align_pkg::*; #(
   parameter int        NUM_CH    = 4,
   parameter int        CNT_W     = 8,
   parameter edge_sel_e SYNC_EDGE = EDGE_RISE
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    samp_en,
   input logic                    sync_in,
   input logic [NUM_CH*CNT_W-1:0] lat_out,
   input logic [NUM_CH-1:0]       lat_valid,
   input logic [NUM_CH-1:0]       lat_ovf,
   input logic [NUM_CH-1:0]       rd_en
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic prev_sync;
   logic seen_edge;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_sync <= (SYNC_EDGE == EDGE_FALL);
      else        prev_sync <= sync_in;
   end

   assign seen_edge = (SYNC_EDGE == EDGE_RISE) ? (sync_in & ~prev_sync)
                                               : (~sync_in & prev_sync);

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_lane
         // R3
         sync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            seen_edge |=> (!lat_valid[i] && !rd_en[i]));
         // R6
         rd_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rd_en[i]) |-> lat_valid[i]);
         // R4
         lat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (lat_valid[i] && $past(lat_valid[i])) |-> $stable(lat_out[i*CNT_W +: CNT_W]));
         // R5
         sat_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            lat_ovf[i] |-> (lat_valid[i] && lat_out[i*CNT_W +: CNT_W] == CNT_MAX));
         // R7
         rd_on_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(rd_en[i]) && $past(lat_valid[i])) |-> $past(samp_en));
      end
   endgenerate
endmodule

bind sync_strobe_align sync_strobe_align_chk #(
   .NUM_CH    (NUM_CH),
   .CNT_W     (CNT_W),
   .SYNC_EDGE (SYNC_EDGE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .samp_en   (samp_en),
   .sync_in   (sync_in),
   .lat_out   (lat_out),
   .lat_valid (lat_valid),
   .lat_ovf   (lat_ovf),
   .rd_en     (rd_en)
);

// File: tb/sim_sync_strobe_align.sv
module sim_sync_strobe_align;
   import sync_align_pkg::*;

   localparam int NCH = 3;
   localparam int CW  = 6;
   localparam int DW  = 4;

   localparam int K_LAT = 0;
   localparam int K_VAL = 1;
   localparam int K_OVF = 2;
   localparam int K_RD  = 3;

   typedef struct {
      int    due;
      int    ch;
      int    kind;
      int    val;
      string req;
   } exp_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              samp_en = 1'b0;
   logic              sync_in = 1'b0;
   logic [NCH-1:0]    strobe_in = '0;
   logic [NCH*DW-1:0] dly_cfg = '0;
   logic [NCH*CW-1:0] lat_out;
   logic [NCH-1:0]    lat_valid;
   logic [NCH-1:0]    lat_ovf;
   logic [NCH-1:0]    rd_en;

   int   cyc = 0;
   int   checks = 0;
   int   failures = 0;
   bit   done = 1'b0;
   exp_t sb[$];

   always #2 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   sync_strobe_align #(
      .NUM_CH(NCH), .CNT_W(CW), .DLY_W(DW), .SYNC_EDGE(EDGE_RISE)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .sync_in(sync_in),
      .strobe_in(strobe_in), .dly_cfg(dly_cfg), .lat_out(lat_out),
      .lat_valid(lat_valid), .lat_ovf(lat_ovf), .rd_en(rd_en)
   );

   function automatic int observe(int ch, int kind);
      case (kind)
         K_LAT:   return int'(lat_out[ch*CW +: CW]);
         K_VAL:   return int'(lat_valid[ch]);
         K_OVF:   return int'(lat_ovf[ch]);
         default: return int'(rd_en[ch]);
      endcase
   endfunction

   task automatic check(string req, string what, int act, int expv);
      checks++;
      if (act != expv) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d (edge %0d)", req, what, act, expv, cyc);
      end
   endtask

   // monitor: compares items due at the current edge count
   always @(negedge clk) begin
      if (rst_n) begin
         int i = 0;
         while (i < sb.size()) begin
            if (sb[i].due == cyc) begin
               check(sb[i].req, $sformatf("ch%0d kind%0d", sb[i].ch, sb[i].kind),
                     observe(sb[i].ch, sb[i].kind), sb[i].val);
               sb.delete(i);
            end else begin
               i++;
            end
         end
      end
   end

   task automatic push(int ch, int kind, int val, string req);
      exp_t e;
      e.due = cyc; e.ch = ch; e.kind = kind; e.val = val; e.req = req;
      sb.push_back(e);
   endtask

   task automatic drive(logic s, logic e, logic [NCH-1:0] st);
      sync_in = s; samp_en = e; strobe_in = st;
      @(posedge clk);
      #1;
   endtask

   task automatic sync_pulse();
      drive(1'b1, 1'b0, '0);
      for (int c = 0; c < NCH; c++) begin
         push(c, K_VAL, 0, "R3");
         push(c, K_RD, 0, "R3");
      end
   endtask

   task automatic se(int n);
      repeat (n) drive(1'b0, 1'b1, '0);
   endtask

   task automatic expect_meas(int ch, int lat, int ovf, string req);
      push(ch, K_LAT, lat, req);
      push(ch, K_VAL, 1, req);
      push(ch, K_OVF, ovf, "R5");
   endtask

   task automatic set_dly(int ch, int d);
      dly_cfg[ch*DW +: DW] = DW'(d);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      check("R1", "lat_out", int'(lat_out), 0);
      check("R1", "flags", int'({lat_valid, lat_ovf, rd_en}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "after release", int'({lat_out, lat_valid, lat_ovf, rd_en}), 0);
      @(posedge clk);
      #1;

      // R2 and R6: gapped sample enables, zero delay
      sync_pulse();
      drive(1'b0, 1'b1, '0);
      drive(1'b0, 1'b0, '0);
      se(2);
      drive(1'b0, 1'b0, 3'b001);
      expect_meas(0, 3, 0, "R2");
      push(0, K_RD, 1, "R6");
      se(2);
      drive(1'b0, 1'b0, 3'b010);
      expect_meas(1, 5, 0, "R2");
      push(1, K_RD, 1, "R6");
      drive(1'b0, 1'b0, 3'b100);
      expect_meas(2, 5, 0, "R2");
      // R4: second strobe ignored
      se(2);
      drive(1'b0, 1'b0, 3'b001);
      push(0, K_LAT, 3, "R4");
      push(0, K_VAL, 1, "R4");

      // R4: strobe together with sync edge not captured
      drive(1'b1, 1'b0, 3'b001);
      push(0, K_VAL, 0, "R4");
      drive(1'b0, 1'b0, '0);
      push(0, K_VAL, 0, "R4");
      drive(1'b0, 1'b0, 3'b001);
      expect_meas(0, 0, 0, "R4");

      // R3: restart mid-measurement
      sync_pulse();
      se(3);
      sync_pulse();
      se(2);
      drive(1'b0, 1'b0, 3'b111);
      for (int c = 0; c < NCH; c++) expect_meas(c, 2, 0, "R3");

      // R5: saturation
      sync_pulse();
      se(70);
      drive(1'b0, 1'b0, 3'b011);
      expect_meas(0, 63, 1, "R5");
      expect_meas(1, 63, 1, "R5");

      // R7: delay of 3, value taken at strobe
      set_dly(0, 3);
      sync_pulse();
      se(1);
      drive(1'b0, 1'b0, 3'b001);
      expect_meas(0, 1, 0, "R7");
      push(0, K_RD, 0, "R7");
      set_dly(0, 1);
      se(1);
      push(0, K_RD, 0, "R7");
      drive(1'b0, 1'b0, '0);
      push(0, K_RD, 0, "R7");
      se(1);
      push(0, K_RD, 0, "R7");
      se(1);
      push(0, K_RD, 1, "R7");

      // R8: alignment across channels
      set_dly(0, 4);
      set_dly(1, 2);
      sync_pulse();
      se(1);
      drive(1'b0, 1'b0, 3'b001);
      expect_meas(0, 1, 0, "R8");
      se(2);
      drive(1'b0, 1'b0, 3'b010);
      expect_meas(1, 3, 0, "R8");
      push(0, K_RD, 0, "R8");
      se(1);
      push(0, K_RD, 0, "R8");
      push(1, K_RD, 0, "R8");
      se(1);
      push(0, K_RD, 1, "R8");
      push(1, K_RD, 1, "R8");

      // R9: held-high sync and falling edge do not restart
      sync_in = 1'b1; samp_en = 1'b1; strobe_in = '0;
      @(posedge clk); #1;
      for (int c = 0; c < NCH; c++) push(c, K_VAL, 0, "R9");
      drive(1'b1, 1'b1, '0);
      drive(1'b1, 1'b1, '0);
      se(2);
      drive(1'b0, 1'b0, 3'b100);
      expect_meas(2, 4, 0, "R9");

      drive(1'b0, 1'b0, '0);
      drive(1'b0, 1'b0, '0);
      @(negedge clk);
      check("R2", "pending scoreboard items", sb.size(), 0);
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL R1 watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule